// File: doc/BRIEF.md
# Exposure Window Sequencer

This block lays out the detector timing windows of one frame around a pulsed X-ray exposure. A frame-start strobe opens a fixed timeline. The timeline runs through a settling blank, then an integration window built from a lead margin, the exposure length and a tail margin, then a switching gap whose first part is blanked, then a readout window. All lengths are counted in sample-clock cycles. They come from programmable registers that are copied into the working set only on the frame-start strobe, so a frame never mixes old and new settings.

An exposure trigger is expected exactly at the end of the lead margin inside the integration window. The block does not re-time a trigger that arrives at another moment. It classifies every trigger and keeps four saturating event counters, which a simple register port reads back and clears with write-one-to-clear: frames without a trigger, frames with more than one, triggers that come after the window, and frames whose single trigger sits off the programmed phase. A one-cycle slip strobe also marks each off-phase frame.

Top module: `exposure_gate_seq`

## Requirements
- R1: After reset the three gates and the slip strobe are low, all four counters read 0, and the settings read lead margin 1, exposure 2, tail margin 1, settle blank 2, readout offset 2, readout length 4.
- R2: With settings latched at a frame-start edge, the cycles after that edge are numbered k = 0, 1, .... The integration gate is high for k in [B, B+I), where B is the settle blank and I = lead + max(exposure,1) + tail. The blank gate is high for k in [0, B).
- R3: Across the gap [B+I, B+I+G), G being the readout offset, the blank gate is high for the first min(B,G) cycles. The blank and readout gates are never high in the same cycle, and at most one of the three gates is high in any cycle.
- R4: The readout gate is high for k in [B+I+G, B+I+G+max(readout length,1)). After that all gates stay low until the next frame start.
- R5: Register map on the 4-bit address: 0 lead margin, 1 exposure, 2 tail margin, 3 settle blank, 4 readout offset, 5 readout length (read/write); 8 miss, 9 duplicate, 10 late, 11 slip counters (read, zero-extended); 15 write-only clear. Other addresses read 0. A write takes effect at the next frame start and reads back at once.
- R6: A frame whose window [0, B+I) saw no trigger increments the miss counter when the window closes.
- R7: A frame whose window saw two or more triggers increments the duplicate counter.
- R8: Every trigger sampled outside a window (gap, readout or no frame active) increments the late counter.
- R9: A frame whose window saw exactly one trigger, not at k = B + lead, increments the slip counter and raises the slip strobe for the one cycle after the window closes.
- R10: A frame start arriving while a window is still open closes that window, judges it under R6, R7 and R9 in that cycle, and then starts the new frame.
- R11: Each counter holds at its all-ones value instead of wrapping.
- R12: A write to address 15 clears the counters whose bits are set (bit 0 miss, bit 1 duplicate, bit 2 late, bit 3 slip). The clear wins over an increment in the same cycle, and counters whose bits are clear keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| xray_trig | input | 1 | One-cycle exposure trigger |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CFG_W | Register write data |
| reg_rdata | output | CFG_W | Register read data (combinational from address) |
| integ_gate | output | 1 | Integration window |
| blank_gate | output | 1 | Blanking window |
| read_gate | output | 1 | Readout window |
| slip_evt | output | 1 | One-cycle off-phase frame strobe |

## Verification
The bench builds the block with 8-bit settings and 3-bit counters. With those widths, nine back-to-back frame starts and ten stray triggers are enough to drive counters into saturation. The short settings keep a full frame at a dozen cycles, so one run covers zero-length settle and gap phases, a zero exposure length, mid-frame register writes, restarts inside an open window and a clear that coincides with an increment. A behavioural timeline model compares every gate, the slip strobe and the read port on every cycle.

// File: rtl/egs_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the exposure window sequencer.
package egs_pkg;
    // Register address width and fixed addresses
    localparam int REG_AW     = 4;
    localparam int A_CNT_BASE = 8;
    localparam logic [REG_AW-1:0] A_CLR = 4'd15;

    // Setting indices (also their register addresses)
    localparam int CFG_PRE   = 0;
    localparam int CFG_EXP   = 1;
    localparam int CFG_POST  = 2;
    localparam int CFG_BLANK = 3;
    localparam int CFG_ROFS  = 4;
    localparam int CFG_RLEN  = 5;
    localparam int NUM_CFG   = 6;

    // Event indices (also clear-bit positions)
    localparam int EVT_MISS = 0;
    localparam int EVT_DUP  = 1;
    localparam int EVT_LATE = 2;
    localparam int EVT_SLIP = 3;
    localparam int NUM_EVT  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_INTEG,
        PH_GAP,
        PH_READ
    } phase_e;
endpackage

// File: rtl/egs_regfile.sv
`timescale 1ns/1ps
// Setting registers, counter read mux and clear decode.
// Assumes CFG_W >= NUM_EVT and CNT_W <= CFG_W.
module egs_regfile
    import egs_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int CNT_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [CFG_W-1:0]                  reg_wdata,
    input  logic [NUM_EVT-1:0][CNT_W-1:0]     evt_cnt,
    output logic [NUM_CFG-1:0][CFG_W-1:0]     cfg_shadow,
    output logic [NUM_EVT-1:0]                evt_clr,
    output logic [CFG_W-1:0]                  reg_rdata
);
    // Reset value of each setting
    function automatic logic [CFG_W-1:0] cfg_init(input int idx);
        case (idx)
            CFG_PRE:   return CFG_W'(1);
            CFG_EXP:   return CFG_W'(2);
            CFG_POST:  return CFG_W'(1);
            CFG_BLANK: return CFG_W'(2);
            CFG_ROFS:  return CFG_W'(2);
            default:   return CFG_W'(4);
        endcase
    endfunction

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        // Store one setting on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_shadow[g] <= cfg_init(g);
            else if (reg_wr && reg_addr == REG_AW'(g))
                cfg_shadow[g] <= reg_wdata;
        end
    end

    // Decode the write-one-to-clear strobe
    always_comb begin
        evt_clr = '0;
        if (reg_wr && reg_addr == A_CLR)
            evt_clr = reg_wdata[NUM_EVT-1:0];
    end

    // Read mux over settings and counters
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (reg_addr == REG_AW'(i))
                reg_rdata = cfg_shadow[i];
        for (int i = 0; i < NUM_EVT; i++)
            if (reg_addr == REG_AW'(A_CNT_BASE + i))
                reg_rdata = CFG_W'(evt_cnt[i]);
    end
endmodule

// File: rtl/egs_window_timer.sv
`timescale 1ns/1ps
// Frame timeline: settle blank, integration, gap, readout.
// Latches the settings on frame_start; a frame start always restarts the timeline.
// Zero exposure or readout length acts as one cycle; zero blank or offset skips the phase.
module egs_window_timer
    import egs_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic [NUM_CFG-1:0][CFG_W-1:0] cfg_shadow,
    output logic                          blank_gate,
    output logic                          integ_gate,
    output logic                          read_gate,
    output logic                          in_window,
    output logic                          on_phase,
    output logic                          win_close
);
    localparam int PH_W = CFG_W + 2;

    phase_e                        st, st_nx;
    logic [PH_W-1:0]               ph, ph_nx, cur_len, len_integ;
    logic [NUM_CFG-1:0][CFG_W-1:0] act;
    logic                          ph_last;

    function automatic logic [PH_W-1:0] at_least_one(input logic [CFG_W-1:0] v);
        return (v == '0) ? PH_W'(1) : PH_W'(v);
    endfunction

    // Working copy of the settings, taken only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= '0;
        else if (frame_start)
            act <= cfg_shadow;
    end

    // Length of the current phase
    always_comb begin
        len_integ = PH_W'(act[CFG_PRE]) + at_least_one(act[CFG_EXP]) + PH_W'(act[CFG_POST]);
        case (st)
            PH_SETTLE: cur_len = PH_W'(act[CFG_BLANK]);
            PH_INTEG:  cur_len = len_integ;
            PH_GAP:    cur_len = PH_W'(act[CFG_ROFS]);
            PH_READ:   cur_len = at_least_one(act[CFG_RLEN]);
            default:   cur_len = '0;
        endcase
        ph_last = (st != PH_IDLE) && (ph == cur_len - PH_W'(1));
    end

    // Next phase and position within it
    always_comb begin
        st_nx = st;
        ph_nx = ph + PH_W'(1);
        if (frame_start) begin
            st_nx = (cfg_shadow[CFG_BLANK] != '0) ? PH_SETTLE : PH_INTEG;
            ph_nx = '0;
        end else if (ph_last) begin
            ph_nx = '0;
            case (st)
                PH_SETTLE: st_nx = PH_INTEG;
                PH_INTEG:  st_nx = (act[CFG_ROFS] != '0) ? PH_GAP : PH_READ;
                PH_GAP:    st_nx = PH_READ;
                default:   st_nx = PH_IDLE;
            endcase
        end else if (st == PH_IDLE) begin
            ph_nx = '0;
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PH_IDLE;
            ph <= '0;
        end else begin
            st <= st_nx;
            ph <= ph_nx;
        end
    end

    // Gate and window decode from the registered phase
    always_comb begin
        integ_gate = (st == PH_INTEG);
        read_gate  = (st == PH_READ);
        blank_gate = (st == PH_SETTLE) ||
                     ((st == PH_GAP) && (ph < PH_W'(act[CFG_BLANK])));
        in_window  = (st == PH_SETTLE) || (st == PH_INTEG);
        on_phase   = (st == PH_INTEG) && (ph == PH_W'(act[CFG_PRE]));
        win_close  = ((st == PH_INTEG) && ph_last) || (frame_start && in_window);
    end
endmodule

// File: rtl/egs_trig_judge.sv
`timescale 1ns/1ps
// Classifies triggers against the open window and judges each frame when it closes.
// Assumes win_close is high for exactly one cycle per opened window.
module egs_trig_judge
    import egs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               xray_trig,
    input  logic               in_window,
    input  logic               on_phase,
    input  logic               win_close,
    output logic [NUM_EVT-1:0] evt_inc,
    output logic               slip_evt
);
    logic [1:0] hits, hits_nx;
    logic       aligned, aligned_nx, hit;

    // Count window hits (capped at two) and note an on-phase hit
    always_comb begin
        hit        = xray_trig && in_window;
        hits_nx    = (hit && hits != 2'd2) ? hits + 2'd1 : hits;
        aligned_nx = aligned || (hit && on_phase);
        evt_inc               = '0;
        evt_inc[EVT_MISS]     = win_close && (hits_nx == 2'd0);
        evt_inc[EVT_DUP]      = win_close && (hits_nx == 2'd2);
        evt_inc[EVT_SLIP]     = win_close && (hits_nx == 2'd1) && !aligned_nx;
        evt_inc[EVT_LATE]     = xray_trig && !in_window;
    end

    // Per-frame trigger record, cleared at frame start
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            hits    <= '0;
            aligned <= 1'b0;
        end else begin
            hits    <= hits_nx;
            aligned <= aligned_nx;
        end
    end

    // One-cycle slip strobe after a judged frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            slip_evt <= 1'b0;
        else
            slip_evt <= evt_inc[EVT_SLIP];
    end
endmodule

// File: rtl/egs_evt_counters.sv
`timescale 1ns/1ps
// Bank of saturating event counters; a clear wins over an increment.
module egs_evt_counters
    import egs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_EVT-1:0]            evt_inc,
    input  logic [NUM_EVT-1:0]            evt_clr,
    output logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
        // Count one event class, holding at all ones
        always_ff @(posedge clk) begin
            if (!rst_n || evt_clr[g])
                evt_cnt[g] <= '0;
            else if (evt_inc[g] && evt_cnt[g] != CNT_MAX)
                evt_cnt[g] <= evt_cnt[g] + CNT_W'(1);
        end
    end
endmodule

// File: rtl/exposure_gate_seq.sv
`timescale 1ns/1ps
// Top of the exposure window sequencer: timeline, trigger judge, counters, registers.
// Assumes frame_start and xray_trig are synchronous one-cycle strobes.
module exposure_gate_seq
    import egs_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              xray_trig,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    output logic              integ_gate,
    output logic              blank_gate,
    output logic              read_gate,
    output logic              slip_evt
);
    logic [NUM_CFG-1:0][CFG_W-1:0] cfg_shadow;
    logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt;
    logic [NUM_EVT-1:0]            evt_inc, evt_clr;
    logic                          in_window, on_phase, win_close;

    egs_regfile #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .evt_cnt(evt_cnt), .cfg_shadow(cfg_shadow),
        .evt_clr(evt_clr), .reg_rdata(reg_rdata)
    );

    egs_window_timer #(.CFG_W(CFG_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_shadow(cfg_shadow),
        .blank_gate(blank_gate), .integ_gate(integ_gate), .read_gate(read_gate),
        .in_window(in_window), .on_phase(on_phase), .win_close(win_close)
    );

    egs_trig_judge u_judge (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .xray_trig(xray_trig),
        .in_window(in_window), .on_phase(on_phase), .win_close(win_close),
        .evt_inc(evt_inc), .slip_evt(slip_evt)
    );

    egs_evt_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .evt_clr(evt_clr), .evt_cnt(evt_cnt)
    );
endmodule

// File: rtl/egs_checker.sv
`timescale 1ns/1ps
// Property checker for the exposure window sequencer, bound to the top.
module egs_checker
    import egs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          frame_start,
    input logic                          integ_gate,
    input logic                          blank_gate,
    input logic                          read_gate,
    input logic                          slip_evt,
    input logic [NUM_EVT-1:0][CNT_W-1:0] evt_cnt,
    input logic [NUM_EVT-1:0]            evt_clr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R3
    blank_read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blank_gate && read_gate));

    // R3
    gate_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({blank_gate, integ_gate, read_gate}));

    // R2
    integ_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(integ_gate) |-> ($past(blank_gate) || $past(frame_start)));

    // R4
    read_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_gate) |-> !$past(frame_start));

    // R9
    slip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_evt |-> $past(integ_gate || blank_gate));

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt_chk
        // R11
        cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_cnt[g] == CNT_MAX && !evt_clr[g]) |=> evt_cnt[g] == CNT_MAX);
        // R11
        cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_clr[g] |=> evt_cnt[g] >= $past(evt_cnt[g]));
        // R12
        cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_clr[g] |=> evt_cnt[g] == '0);
    end
endmodule

bind exposure_gate_seq egs_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .integ_gate(integ_gate), .blank_gate(blank_gate), .read_gate(read_gate),
    .slip_evt(slip_evt), .evt_cnt(evt_cnt), .evt_clr(evt_clr)
);

// File: tb/tb_exposure_gate_seq.sv
`timescale 1ns/1ps
module tb_exposure_gate_seq;
    localparam int CFG_W = 8;
    localparam int CNT_W = 3;
    localparam int CMAX  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             xray_trig = 1'b0;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = 4'd0;
    logic [CFG_W-1:0] reg_wdata = '0;
    logic [CFG_W-1:0] reg_rdata;
    logic             integ_gate, blank_gate, read_gate, slip_evt;

    always #2.5 clk = ~clk;

    exposure_gate_seq #(.CFG_W(CFG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .xray_trig(xray_trig),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .integ_gate(integ_gate), .blank_gate(blank_gate), .read_gate(read_gate),
        .slip_evt(slip_evt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference: frame timeline as a cycle index k
    bit m_act, m_slip, tok;
    int k, aB, aI, aG, aR, aP, tcnt;
    int shadow [6];
    int cnt [4];
    int rot = 0;

    function automatic int eff1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        bit in_win;
        bit inc [4];
        int clr;
        if (!rst_n) begin
            m_act = 0; m_slip = 0; tok = 0; k = 0; tcnt = 0;
            aB = 0; aI = 0; aG = 0; aR = 0; aP = 0;
            shadow = '{1, 2, 1, 2, 2, 4};
            cnt = '{0, 0, 0, 0};
        end else begin
            inc = '{0, 0, 0, 0};
            in_win = m_act && (k < aB + aI);
            if (xray_trig) begin
                if (in_win) begin
                    tcnt++;
                    if (k == aB + aP) tok = 1;
                end else inc[2] = 1;
            end
            if (in_win && (k == aB + aI - 1 || frame_start)) begin
                if (tcnt == 0) inc[0] = 1;
                if (tcnt > 1) inc[1] = 1;
                if (tcnt == 1 && !tok) inc[3] = 1;
            end
            clr = (reg_wr && reg_addr == 4'd15) ? int'(reg_wdata[3:0]) : 0;
            for (int i = 0; i < 4; i++) begin
                if (clr[i]) cnt[i] = 0;
                else if (inc[i] && cnt[i] < CMAX) cnt[i]++;
            end
            m_slip = inc[3];
            if (frame_start) begin
                aP = shadow[0]; aB = shadow[3]; aG = shadow[4]; aR = eff1(shadow[5]);
                aI = shadow[0] + eff1(shadow[1]) + shadow[2];
                m_act = 1; k = 0; tcnt = 0; tok = 0;
            end else if (m_act) begin
                k++;
                if (k >= aB + aI + aG + aR) m_act = 0;
            end
            if (reg_wr && reg_addr < 4'd6) shadow[reg_addr] = int'(reg_wdata);
        end
    end

    function automatic int exp_rdata(int a);
        if (a < 6) return shadow[a];
        if (a >= 8 && a < 12) return cnt[a - 8];
        return 0;
    endfunction

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int gap_blank;
            gap_blank = (aB < aG) ? aB : aG;
            chk("R2 integ_gate", integ_gate, m_act && k >= aB && k < aB + aI);
            chk("R3 blank_gate", blank_gate,
                m_act && (k < aB || (k >= aB + aI && k < aB + aI + gap_blank)));
            chk("R4 read_gate", read_gate,
                m_act && k >= aB + aI + aG && k < aB + aI + aG + aR);
            chk("R9 slip_evt", slip_evt, m_slip);
            case (reg_addr)
                4'd8:    chk("R6 rdata", reg_rdata, exp_rdata(8));
                4'd9:    chk("R7 rdata", reg_rdata, exp_rdata(9));
                4'd10:   chk("R8 rdata", reg_rdata, exp_rdata(10));
                4'd11:   chk("R9 rdata", reg_rdata, exp_rdata(11));
                default: chk("R5 rdata", reg_rdata, exp_rdata(int'(reg_addr)));
            endcase
        end
    end

    // One clock: wait the edge, drop strobes, rotate the read address
    task automatic cyc();
        @(posedge clk); #1;
        frame_start = 0; xray_trig = 0; reg_wr = 0;
        rot = (rot + 1) % 10;
        reg_addr = 4'((rot < 6) ? rot : rot + 2);
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = CFG_W'(d);
        cyc();
    endtask

    task automatic frame(int len, int t1, int t2);
        frame_start = 1;
        cyc();
        for (int c = 0; c < len; c++) begin
            if (c == t1 || c == t2) xray_trig = 1;
            cyc();
        end
    endtask

    task automatic read_chk(int a, int exp, string tag);
        reg_addr = 4'(a);
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1 gates", {integ_gate, blank_gate, read_gate, slip_evt}, 0);
        read_chk(0, 1, "R1 lead");   read_chk(1, 2, "R1 exposure");
        read_chk(2, 1, "R1 tail");   read_chk(3, 2, "R1 blank");
        read_chk(4, 2, "R1 offset"); read_chk(5, 4, "R1 rlen");
        read_chk(8, 0, "R1 miss");   read_chk(11, 0, "R1 slip");
        cyc();
        frame(14, 3, -1);                        // aligned frame
        read_chk(11, 0, "R9 no slip on phase");
        frame(14, -1, -1);                       // no trigger
        read_chk(8, 1, "R6 miss");
        frame(14, 1, 3);                         // two triggers
        read_chk(9, 1, "R7 dup");
        frame(14, 4, -1);                        // off phase
        read_chk(11, 1, "R9 slip");
        frame(14, 7, 12);                        // gap and idle triggers
        read_chk(10, 2, "R8 late");
        // R5 mid-frame writes apply from the next frame
        frame_start = 1; cyc();
        wr(3, 0); wr(4, 0); wr(1, 0);
        read_chk(3, 0, "R5 readback");
        repeat (12) cyc();
        frame(10, 1, -1);
        wr(1, 3); wr(3, 4); wr(4, 5); wr(5, 2);
        frame(20, 5, -1);
        read_chk(11, 1, "R5 aligned after change");
        // R10 restart inside an open window with one off-phase trigger
        frame_start = 1; cyc();
        cyc(); xray_trig = 1; cyc(); cyc();
        frame(30, -1, -1);
        read_chk(11, 2, "R10 restart judged");
        // R11 saturation
        for (int i = 0; i < 9; i++) begin frame_start = 1; cyc(); end
        repeat (20) cyc();
        for (int i = 0; i < 10; i++) begin xray_trig = 1; cyc(); end
        read_chk(8, CMAX, "R11 miss saturates");
        read_chk(10, CMAX, "R11 late saturates");
        // R12 selective clear, and clear beating an increment
        wr(15, 1);
        read_chk(8, 0, "R12 miss cleared");
        read_chk(10, CMAX, "R12 late kept");
        reg_wr = 1; reg_addr = 4'd15; reg_wdata = CFG_W'(4); xray_trig = 1;
        cyc();
        read_chk(10, 0, "R12 clear wins");
        read_chk(9, 1, "R12 dup kept");
        repeat (4) cyc();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected done");
            done = 1;
            finish_run();
        end
    end
endmodule